// File: doc/BRIEF.md
# Digitizer Front-End Configuration and Mode Controller

This block keeps the programmable settings of a four-range charge digitizer front end and selects the operating mode of that front end. A host moves a configuration word in one bit per clock on a serial input. This happens only while the mode input requests programming. The bits that fall out of the far end of the shift chain appear on a serial output, so several devices can share one serial line in a daisy chain. When programming ends, a shadow copy takes the whole word in a single clock. The shadow copy alone drives the analog control codes: discriminator threshold, pedestal, one pedestal trim per capacitor phase, fixed-range forcing, injection level and input bias.

The block also runs a four-phase capacitor counter and produces one-hot mode decodes. In injection mode it pulses a strobe once per capacitor rotation, on phase 0. It resolves the range in use from the automatic range input and the forcing control. It delivers the per-phase trim only when the lowest range is in use.

Top module: `qdc_cfg_ctrl`

## Requirements
- R1: `mode_sel` is decoded as 00 = Normal, 01 = Program, 10 = Charge Inject, and 11 is treated as Normal. The decodes `is_normal`, `is_program` and `is_inject` are registered, so they follow `mode_sel` one clock later, and exactly one of them is high.
- R2: The chain shifts at a clock edge only while `mode_sel` is 01. The bit on `ser_in` enters at the bottom, and `ser_out` shows the top bit of the chain. While loading a second word, `ser_out` therefore emits the previous word, top bit first. In any other mode the chain and `ser_out` hold their values.
- R3: The configuration word is 40 bits wide. Its fields are: bias [3:0], injection level [6:4], forced range value [8:7], force enable [9], phase trims [25:10] (4 bits per phase, phase 0 lowest), pedestal [31:26] and threshold [39:32]. The first bit shifted in ends up at bit 39.
- R4: The control outputs change only at the clock edge where the registered mode is Program and `mode_sel` no longer requests Program. At that edge they take the complete shifted word. Partial shifting never reaches them.
- R5: `cap_phase` is 0 after reset and increments by one each clock, wrapping modulo 4.
- R6: `inj_strobe` is high exactly in the cycles where `is_inject` is high and `cap_phase` is 0. This gives one single-cycle pulse every four clocks in Charge Inject mode.
- R7: `eff_range` equals the forced range value when force enable is 1, and `rng_auto` otherwise.
- R8: `trim_active` equals the trim of the current `cap_phase` when `eff_range` is 0, and is zero for every other range.
- R9: `inj_range` is the upper two bits of the injection level and `inj_upper` is its lowest bit. This places two test points in each of the four ranges.
- R10: A synchronous reset clears the chain, the shadow word and the phase counter, selects Normal mode and disables range forcing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Requested operating mode |
| ser_in | input | 1 | Serial configuration data in |
| ser_out | output | 1 | Serial data out to the next device |
| rng_auto | input | 2 | Range chosen by the automatic range logic |
| disc_thresh | output | 8 | Timing discriminator threshold code |
| ped_code | output | 6 | Pedestal DAC code |
| phase_trims | output | 16 | Per-phase pedestal trims, phase 0 in the low bits |
| trim_active | output | 4 | Trim applied for the current phase on the lowest range |
| force_en | output | 1 | Fixed-range forcing enabled |
| eff_range | output | 2 | Range actually in use |
| inj_level | output | 3 | Charge injection level code |
| inj_range | output | 2 | Range targeted by the injection level |
| inj_upper | output | 1 | Upper test point within that range |
| bias_code | output | 4 | Input bias code |
| is_normal | output | 1 | Normal mode decode |
| is_program | output | 1 | Program mode decode |
| is_inject | output | 1 | Charge Inject mode decode |
| cap_phase | output | 2 | Capacitor phase counter |
| inj_strobe | output | 1 | Injection strobe |

## Verification
The shift chain, the shadow word, the mode decodes, the phase counter and the strobe are all registers. Each of them shows the effect of an input one clock edge after that input is applied. The range and trim outputs are combinational from state and `rng_auto`, so they are valid in the same cycle as the input. The bench drives inputs between edges. It samples one time unit after each rising edge, so it compares the registered results for the edge just taken. For the combinational outputs it samples one time unit after changing `rng_auto`. The daisy-chain output is sampled before each shift edge, because that is when it shows the bit about to leave.

// File: rtl/qdc_cfg_pkg.sv
package qdc_cfg_pkg;

    localparam int RANGE_W = 2;
    localparam int INJ_W   = RANGE_W + 1;

    typedef enum logic [1:0] {
        MODE_NORM = 2'b00,
        MODE_PROG = 2'b01,
        MODE_INJ  = 2'b10
    } qdc_mode_e;

    // Unused code 11 falls back to Normal.
    function automatic qdc_mode_e decode_mode(input logic [1:0] sel);
        case (sel)
            2'b01:   return MODE_PROG;
            2'b10:   return MODE_INJ;
            default: return MODE_NORM;
        endcase
    endfunction

endpackage

// File: rtl/qdc_mode_seq.sv
module qdc_mode_seq
    import qdc_cfg_pkg::*;
#(
    parameter int N_PHASE = 4,
    localparam int PH_W   = $clog2(N_PHASE)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode_sel,
    output qdc_mode_e       mode_q_o,
    output logic [PH_W-1:0] phase_o,
    output logic            strobe_o,
    output logic            shift_en_o,
    output logic            prog_exit_o
);

    typedef struct packed {
        qdc_mode_e       mode;
        logic [PH_W-1:0] phase;
        logic            strobe;
    } seq_t;

    seq_t      st_d, st_q;
    qdc_mode_e req_mode;

    always_comb begin
        req_mode    = decode_mode(mode_sel);
        st_d        = st_q;
        st_d.mode   = req_mode;
        st_d.phase  = st_q.phase + 1'b1;
        st_d.strobe = (st_d.mode == MODE_INJ) && (st_d.phase == '0);
        if (rst) begin
            st_d.mode   = MODE_NORM;
            st_d.phase  = '0;
            st_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_q_o    = st_q.mode;
    assign phase_o     = st_q.phase;
    assign strobe_o    = st_q.strobe;
    assign shift_en_o  = (req_mode == MODE_PROG);
    assign prog_exit_o = (st_q.mode == MODE_PROG) && (req_mode != MODE_PROG);

endmodule

// File: rtl/qdc_cfg_chain.sv
module qdc_cfg_chain #(
    parameter int CFG_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             load_en,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [CFG_W-1:0] shadow_o
);

    typedef struct packed {
        logic [CFG_W-1:0] chain;
        logic [CFG_W-1:0] shadow;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.chain = {st_q.chain[CFG_W-2:0], ser_in};
        end
        if (load_en) begin
            st_d.shadow = st_q.chain;
        end
        if (rst) begin
            st_d.chain  = '0;
            st_d.shadow = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ser_out  = st_q.chain[CFG_W-1];
    assign shadow_o = st_q.shadow;

endmodule

// File: rtl/qdc_cfg_ctrl.sv
module qdc_cfg_ctrl
    import qdc_cfg_pkg::*;
#(
    parameter int TW      = 8,
    parameter int PW      = 6,
    parameter int PPW     = 4,
    parameter int BW      = 4,
    parameter int N_PHASE = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode_sel,
    input  logic                   ser_in,
    output logic                   ser_out,
    input  logic [RANGE_W-1:0]     rng_auto,
    output logic [TW-1:0]          disc_thresh,
    output logic [PW-1:0]          ped_code,
    output logic [N_PHASE*PPW-1:0] phase_trims,
    output logic [PPW-1:0]         trim_active,
    output logic                   force_en,
    output logic [RANGE_W-1:0]     eff_range,
    output logic [INJ_W-1:0]       inj_level,
    output logic [RANGE_W-1:0]     inj_range,
    output logic                   inj_upper,
    output logic [BW-1:0]          bias_code,
    output logic                   is_normal,
    output logic                   is_program,
    output logic                   is_inject,
    output logic [$clog2(N_PHASE)-1:0] cap_phase,
    output logic                   inj_strobe
);

    localparam int PH_W    = $clog2(N_PHASE);
    localparam int BIAS_LO = 0;
    localparam int INJ_LO  = BIAS_LO + BW;
    localparam int FVAL_LO = INJ_LO + INJ_W;
    localparam int FEN_BIT = FVAL_LO + RANGE_W;
    localparam int TRIM_LO = FEN_BIT + 1;
    localparam int PED_LO  = TRIM_LO + N_PHASE * PPW;
    localparam int THR_LO  = PED_LO + PW;
    localparam int CFG_W   = THR_LO + TW;

    qdc_mode_e        mode_q;
    logic             shift_en;
    logic             prog_exit;
    logic [CFG_W-1:0] shadow;
    logic [PPW-1:0]   trim_arr [N_PHASE];
    logic [RANGE_W-1:0] force_val;

    qdc_mode_seq #(.N_PHASE(N_PHASE)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .mode_q_o    (mode_q),
        .phase_o     (cap_phase),
        .strobe_o    (inj_strobe),
        .shift_en_o  (shift_en),
        .prog_exit_o (prog_exit)
    );

    qdc_cfg_chain #(.CFG_W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .load_en  (prog_exit),
        .ser_in   (ser_in),
        .ser_out  (ser_out),
        .shadow_o (shadow)
    );

    generate
        for (genvar p = 0; p < N_PHASE; p++) begin : g_trim
            assign trim_arr[p] = shadow[TRIM_LO + p*PPW +: PPW];
        end
    endgenerate

    assign bias_code   = shadow[BIAS_LO +: BW];
    assign inj_level   = shadow[INJ_LO +: INJ_W];
    assign force_val   = shadow[FVAL_LO +: RANGE_W];
    assign force_en    = shadow[FEN_BIT];
    assign phase_trims = shadow[TRIM_LO +: N_PHASE*PPW];
    assign ped_code    = shadow[PED_LO +: PW];
    assign disc_thresh = shadow[THR_LO +: TW];

    assign inj_range = inj_level[INJ_W-1:1];
    assign inj_upper = inj_level[0];

    always_comb begin
        eff_range   = force_en ? force_val : rng_auto;
        trim_active = (eff_range == '0) ? trim_arr[cap_phase] : '0;
    end

    assign is_normal  = (mode_q == MODE_NORM);
    assign is_program = (mode_q == MODE_PROG);
    assign is_inject  = (mode_q == MODE_INJ);

endmodule

// File: rtl/qdc_cfg_ctrl_chk.sv
module qdc_cfg_ctrl_chk #(
    parameter int TW   = 8,
    parameter int PW   = 6,
    parameter int PH_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      mode_sel,
    input logic            ser_out,
    input logic [TW-1:0]   disc_thresh,
    input logic [PW-1:0]   ped_code,
    input logic            force_en,
    input logic [1:0]      rng_auto,
    input logic [1:0]      eff_range,
    input logic            is_normal,
    input logic            is_program,
    input logic            is_inject,
    input logic [PH_W-1:0] cap_phase,
    input logic            inj_strobe
);

    a_r1_onehot_mode: assert property (@(posedge clk) disable iff (rst)
        $countones({is_normal, is_program, is_inject}) == 1);

    a_r2_frozen_chain: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'b01) |=> $stable(ser_out));

    a_r4_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !(is_program && mode_sel != 2'b01) |=> ($stable(disc_thresh) && $stable(ped_code)));

    a_r5_phase_step: assert property (@(posedge clk) disable iff (rst)
        (cap_phase == PH_W'(1)) |=> (cap_phase == PH_W'(2)));

    a_r6_strobe_aligned: assert property (@(posedge clk) disable iff (rst)
        inj_strobe |-> (is_inject && cap_phase == '0));

    a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
        inj_strobe |=> !inj_strobe);

    a_r7_unforced_range: assert property (@(posedge clk) disable iff (rst)
        !force_en |-> (eff_range == rng_auto));

endmodule

bind qdc_cfg_ctrl qdc_cfg_ctrl_chk #(.TW(TW), .PW(PW), .PH_W(PH_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_sel    (mode_sel),
    .ser_out     (ser_out),
    .disc_thresh (disc_thresh),
    .ped_code    (ped_code),
    .force_en    (force_en),
    .rng_auto    (rng_auto),
    .eff_range   (eff_range),
    .is_normal   (is_normal),
    .is_program  (is_program),
    .is_inject   (is_inject),
    .cap_phase   (cap_phase),
    .inj_strobe  (inj_strobe)
);

// File: tb/qdc_cfg_ctrl_tb.sv
module qdc_cfg_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_sel;
    logic        ser_in;
    logic        ser_out;
    logic [1:0]  rng_auto;
    logic [7:0]  disc_thresh;
    logic [5:0]  ped_code;
    logic [15:0] phase_trims;
    logic [3:0]  trim_active;
    logic        force_en;
    logic [1:0]  eff_range;
    logic [2:0]  inj_level;
    logic [1:0]  inj_range;
    logic        inj_upper;
    logic [3:0]  bias_code;
    logic        is_normal, is_program, is_inject;
    logic [1:0]  cap_phase;
    logic        inj_strobe;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] cur_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdc_cfg_ctrl u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ser_in(ser_in), .ser_out(ser_out),
        .rng_auto(rng_auto), .disc_thresh(disc_thresh), .ped_code(ped_code),
        .phase_trims(phase_trims), .trim_active(trim_active), .force_en(force_en),
        .eff_range(eff_range), .inj_level(inj_level), .inj_range(inj_range),
        .inj_upper(inj_upper), .bias_code(bias_code), .is_normal(is_normal),
        .is_program(is_program), .is_inject(is_inject), .cap_phase(cap_phase),
        .inj_strobe(inj_strobe)
    );

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] pack_cfg(input logic [7:0] thr, input logic [5:0] ped,
        input logic [15:0] trims, input logic fen, input logic [1:0] fval,
        input logic [2:0] inj, input logic [3:0] bias);
        return {thr, ped, trims, fen, fval, inj, bias};
    endfunction

    // Shift a word in, top bit first; optionally compare ser_out with the previous word.
    task automatic shift_word(input logic [W-1:0] v, input logic [W-1:0] prev, input bit check_out);
        mode_sel = 2'b01;
        for (int i = W - 1; i >= 0; i--) begin
            ser_in = v[i];
            #1;
            if (check_out) chk("R2 daisy out", ser_out, prev[i]);
            tick();
        end
    endtask

    task automatic check_fields(input logic [W-1:0] v);
        chk("R3 threshold", disc_thresh, v[39:32]);
        chk("R3 pedestal", ped_code, v[31:26]);
        chk("R3 trims", phase_trims, v[25:10]);
        chk("R3 force en", force_en, v[9]);
        chk("R3 inject level", inj_level, v[6:4]);
        chk("R3 bias", bias_code, v[3:0]);
        chk("R9 inj range", inj_range, v[6:5]);
        chk("R9 inj upper", inj_upper, v[4]);
    endtask

    task automatic check_range(input logic [W-1:0] v);
        logic [1:0] er;
        logic [3:0] tr;
        for (int r = 0; r < 4; r++) begin
            rng_auto = 2'(r);
            #1;
            er = v[9] ? v[8:7] : 2'(r);
            tr = (er == 2'd0) ? v[10 + 4*cap_phase +: 4] : 4'd0;
            chk("R7 eff range", eff_range, er);
            chk("R8 trim active", trim_active, tr);
        end
    endtask

    initial begin
        logic [W-1:0] nv;
        logic [1:0]   ph;
        int           strobes;
        void'($urandom(32'd1234));
        rst = 1'b1; mode_sel = 2'b00; ser_in = 1'b0; rng_auto = 2'd0;
        tick(); tick();
        rst = 1'b0;
        #1;
        // R10 reset state
        chk("R10 thresh reset", disc_thresh, 0);
        chk("R10 force off", force_en, 0);
        chk("R10 normal", {is_normal, is_program, is_inject}, 3'b100);
        chk("R10 ser_out reset", ser_out, 0);
        chk("R5 phase reset", cap_phase, 0);
        chk("R6 no strobe", inj_strobe, 0);

        // R5 phase stepping
        ph = cap_phase;
        for (int i = 0; i < 6; i++) begin
            tick();
            ph = ph + 2'd1;
            chk("R5 phase step", cap_phase, ph);
        end

        // Directed corner: all ones, then exit and check
        cur_cfg = '0;
        nv = {W{1'b1}};
        shift_word(nv, cur_cfg, 1'b1);
        chk("R1 program decode", {is_normal, is_program, is_inject}, 3'b010);
        chk("R4 no update while shifting", disc_thresh, 8'h00);
        mode_sel = 2'b00;
        tick();
        check_fields(nv);
        cur_cfg = nv;

        // Random loads with daisy checks
        for (int n = 0; n < 20; n++) begin
            nv = pack_cfg(8'($urandom), 6'($urandom), 16'($urandom), 1'($urandom),
                          2'($urandom), 3'($urandom), 4'($urandom));
            shift_word(nv, cur_cfg, 1'b1);
            chk("R4 held until exit", disc_thresh, cur_cfg[39:32]);
            mode_sel = (n % 2 == 0) ? 2'b00 : 2'b11;
            tick();
            check_fields(nv);
            cur_cfg = nv;
            check_range(nv);
        end

        // R4 partial shift then exit: shadow takes partial chain; stays stable during shifting
        mode_sel = 2'b01;
        for (int i = 0; i < 5; i++) begin
            ser_in = 1'b0;
            tick();
            chk("R4 stable mid-shift", {disc_thresh, ped_code}, {cur_cfg[39:32], cur_cfg[31:26]});
        end
        mode_sel = 2'b00;
        tick();
        cur_cfg = {cur_cfg[W-6:0], 5'b0};
        check_fields(cur_cfg);

        // R2 frozen outside Program
        nv = cur_cfg;
        for (int i = 0; i < 8; i++) begin
            ser_in = ~ser_in;
            mode_sel = (i % 2 == 0) ? 2'b10 : 2'b00;
            tick();
            chk("R2 ser_out frozen", ser_out, nv[W-1]);
        end
        check_fields(nv);

        // R1 code 11 -> Normal
        mode_sel = 2'b11;
        tick();
        chk("R1 code 11 normal", {is_normal, is_program, is_inject}, 3'b100);

        // R6 inject strobe
        mode_sel = 2'b10;
        tick();
        chk("R1 inject decode", {is_normal, is_program, is_inject}, 3'b001);
        strobes = 0;
        for (int i = 0; i < 16; i++) begin
            chk("R6 strobe phase", inj_strobe, cap_phase == 2'd0);
            if (inj_strobe) strobes++;
            tick();
        end
        chk("R6 strobe count", strobes, 4);
        mode_sel = 2'b00;
        tick();
        for (int i = 0; i < 4; i++) begin
            chk("R6 no strobe normal", inj_strobe, 0);
            tick();
        end

        // R8 trims across phases with forcing off on lowest range
        nv = pack_cfg(8'h5A, 6'h11, 16'hC3A5, 1'b0, 2'd2, 3'd5, 4'h9);
        shift_word(nv, cur_cfg, 1'b1);
        mode_sel = 2'b00;
        tick();
        cur_cfg = nv;
        rng_auto = 2'd0;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R8 phase trim", trim_active, nv[10 + 4*cap_phase +: 4]);
            tick();
        end
        check_range(nv);

        // R10 reset mid-operation
        mode_sel = 2'b10;
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        mode_sel = 2'b00;
        #1;
        chk("R10 shadow cleared", {disc_thresh, ped_code, force_en, bias_code}, 0);
        chk("R10 mode normal", {is_normal, is_program, is_inject}, 3'b100);
        chk("R10 phase cleared", cap_phase, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule